// File: doc/BRIEF.md
# Bidding Interrupt Arbiter With Vector

This block picks which interrupt source of a two-channel serial port should be serviced next. Each channel offers a receive-data source, a transmit-space source and seven event sources (change of state, address match, flow-control character, receive watchdog, break change, counter/timer, loop-back error). A source that is both active and unmasked places a bid. Receive and transmit bids are the FIFO byte count plus a programmable offset. Event bids are programmable constants. The highest bid wins. It counts as an interrupt only when it is strictly greater than a programmable threshold.

The interrupt request output is re-evaluated on every clock, whether or not the strobe is pulsed. When the host pulses the update strobe, the current-interrupt vector register captures the present winner: its class, its channel, and either its byte count or its event code. The host reads this vector to decide what to service. All inputs are plain levels sampled on each clock, and there is no handshake. The detection logic of the sources themselves lives outside this block.

Source numbering, used for tie-breaking and in the flat input vectors: index = channel*9 + k, where channel 0 is A and channel 1 is B. k=0 is receive, k=1 is transmit, and k=2..8 is the event whose code is k-1.

Top module: `irqbid_arbiter`

## Requirements
- R1: A source competes only when its bit in `src_act` and its bit in `src_en` are both 1. A masked or idle source never wins, whatever its bid.
- R2: A transmit source whose free count (`tx_free`) is zero, meaning its FIFO is full, never competes.
- R3: A receive bid is the fill count plus `rx_ofs`, and a transmit bid is the free count plus `tx_ofs`. Both saturate at 2^BID_W-1. An event bid is its `oth_bid` field taken unchanged.
- R4: The competing source with the largest bid wins. On equal bids the lower source index wins: channel A before B, then receive, then transmit, then events in ascending code order.
- R5: A winner exists only when its bid is strictly greater than `thresh`. On a strobe with no such winner, the vector loads 0x00.
- R6: For a receive or transmit winner, the vector holds class bits [7:6] = 01 for receive or 10 for transmit, the byte count in [5:1] (fill count for receive, free count for transmit), and the channel in bit 0 (0 = A).
- R7: For an event winner, the vector holds [7:6] = 11, [5:4] = 00, the event code in [3:1], and the channel in bit 0. The codes are: 1 change of state, 2 address match, 3 flow-control character, 4 receive watchdog, 5 break change, 6 counter/timer, 7 loop-back error.
- R8: The vector changes only on the clock edge at which `upd_strobe` is 1, and it holds its value at every other edge.
- R9: `irq` is registered. After each clock edge it is 1 exactly when, at that edge, some competing bid was greater than `thresh`. The strobe has no effect on it.
- R10: While `rst_n` is 0, `cir` and `irq` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_act | input | 18 | Per-source active flags, indexed as above |
| src_en | input | 18 | Per-source mask enables |
| rx_fill | input | 10 | Receive FIFO fill count, 5 bits per channel, A in the low bits |
| tx_free | input | 10 | Transmit FIFO free count, 5 bits per channel |
| rx_ofs | input | 2*BID_W | Receive bid offset per channel |
| tx_ofs | input | 2*BID_W | Transmit bid offset per channel |
| oth_bid | input | 14*BID_W | Event bids, field (channel*7 + code-1) |
| thresh | input | BID_W | Bid threshold |
| upd_strobe | input | 1 | Load the vector register from the current winner |
| irq | output | 1 | Interrupt request |
| cir | output | 8 | Current-interrupt vector |

## Verification
The bench targets the tie rules across every neighbouring pair of the ordering. A design that compares with >= instead of > would hand each tie to the later source, and the wrong channel or class would appear in the vector. It sets a bid exactly equal to the threshold, which an off-by-one comparison would wrongly report as an interrupt. It sets a receive count and offset whose sum wraps past 8 bits, so that a design without saturation loses to a slightly smaller event bid. A full transmitter with a huge offset must not appear. The bench also moves the bids between strobes, which catches a vector register that loads on every edge and an `irq` that waits for the strobe.

// File: rtl/irqbid_pkg.sv
package irqbid_pkg;
  localparam int NCH   = 2;
  localparam int NOTH  = 7;
  localparam int SPC   = 2 + NOTH;
  localparam int NSRC  = NCH * SPC;
  localparam int CNT_W = 5;
  localparam int IDX_W = $clog2(NSRC);

  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_RX   = 2'b01,
    CLS_TX   = 2'b10,
    CLS_OTH  = 2'b11
  } irq_class_e;

  typedef struct packed {
    irq_class_e       cls;
    logic [CNT_W-1:0] body;
    logic             chan;
  } cir_t;
endpackage

// File: rtl/irqbid_bidgen.sv
module irqbid_bidgen
  import irqbid_pkg::*;
#(
  parameter int BID_W = 8
) (
  input  logic [NSRC-1:0]           src_act,
  input  logic [NSRC-1:0]           src_en,
  input  logic [NCH*CNT_W-1:0]      rx_fill,
  input  logic [NCH*CNT_W-1:0]      tx_free,
  input  logic [NCH*BID_W-1:0]      rx_ofs,
  input  logic [NCH*BID_W-1:0]      tx_ofs,
  input  logic [NCH*NOTH*BID_W-1:0] oth_bid,
  output logic [NSRC*BID_W-1:0]     bid_flat,
  output logic [NSRC-1:0]           elig
);
  localparam logic [BID_W-1:0] BID_MAX = '1;
  localparam int PAD_W = BID_W + 1 - CNT_W;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [BID_W:0] rx_sum;
    logic [BID_W:0] tx_sum;
    logic [CNT_W-1:0] rx_cnt;
    logic [CNT_W-1:0] tx_cnt;

    assign rx_cnt = rx_fill[ch*CNT_W +: CNT_W];
    assign tx_cnt = tx_free[ch*CNT_W +: CNT_W];
    assign rx_sum = {1'b0, rx_ofs[ch*BID_W +: BID_W]} + {{PAD_W{1'b0}}, rx_cnt};
    assign tx_sum = {1'b0, tx_ofs[ch*BID_W +: BID_W]} + {{PAD_W{1'b0}}, tx_cnt};

    assign bid_flat[(ch*SPC)*BID_W +: BID_W]   = rx_sum[BID_W] ? BID_MAX : rx_sum[BID_W-1:0];
    assign bid_flat[(ch*SPC+1)*BID_W +: BID_W] = tx_sum[BID_W] ? BID_MAX : tx_sum[BID_W-1:0];

    assign elig[ch*SPC]   = src_act[ch*SPC] & src_en[ch*SPC];
    assign elig[ch*SPC+1] = src_act[ch*SPC+1] & src_en[ch*SPC+1] & (tx_cnt != '0);

    for (genvar o = 0; o < NOTH; o++) begin : g_oth
      assign bid_flat[(ch*SPC+2+o)*BID_W +: BID_W] = oth_bid[(ch*NOTH+o)*BID_W +: BID_W];
      assign elig[ch*SPC+2+o] = src_act[ch*SPC+2+o] & src_en[ch*SPC+2+o];
    end
  end
endmodule

// File: rtl/irqbid_arb.sv
module irqbid_arb
  import irqbid_pkg::*;
#(
  parameter int BID_W = 8
) (
  input  logic [NSRC*BID_W-1:0] bid_flat,
  input  logic [NSRC-1:0]       elig,
  output logic                  win_valid,
  output logic [IDX_W-1:0]      win_idx,
  output logic [BID_W-1:0]      win_bid
);
  // Scan in index order; a later source replaces only on a strictly larger bid,
  // so equal bids stay with the lower index.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_bid   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && (!win_valid || bid_flat[i*BID_W +: BID_W] > win_bid)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(i);
        win_bid   = bid_flat[i*BID_W +: BID_W];
      end
    end
  end
endmodule

// File: rtl/irqbid_enc.sv
module irqbid_enc
  import irqbid_pkg::*;
(
  input  logic                 hit,
  input  logic [IDX_W-1:0]     win_idx,
  input  logic [NCH*CNT_W-1:0] rx_fill,
  input  logic [NCH*CNT_W-1:0] tx_free,
  output cir_t                 vec
);
  always_comb begin
    int ch_i;
    int k_i;
    ch_i = int'(win_idx) / SPC;
    k_i  = int'(win_idx) % SPC;
    vec  = '0;
    if (hit) begin
      vec.chan = ch_i[0];
      if (k_i == 0) begin
        vec.cls  = CLS_RX;
        vec.body = rx_fill[ch_i*CNT_W +: CNT_W];
      end else if (k_i == 1) begin
        vec.cls  = CLS_TX;
        vec.body = tx_free[ch_i*CNT_W +: CNT_W];
      end else begin
        vec.cls  = CLS_OTH;
        vec.body = CNT_W'(k_i - 1);
      end
    end
  end
endmodule

// File: rtl/irqbid_arbiter.sv
module irqbid_arbiter
  import irqbid_pkg::*;
#(
  parameter int BID_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           src_act,
  input  logic [NSRC-1:0]           src_en,
  input  logic [NCH*CNT_W-1:0]      rx_fill,
  input  logic [NCH*CNT_W-1:0]      tx_free,
  input  logic [NCH*BID_W-1:0]      rx_ofs,
  input  logic [NCH*BID_W-1:0]      tx_ofs,
  input  logic [NCH*NOTH*BID_W-1:0] oth_bid,
  input  logic [BID_W-1:0]          thresh,
  input  logic                      upd_strobe,
  output logic                      irq,
  output logic [7:0]                cir
);
  logic [NSRC*BID_W-1:0] bid_flat;
  logic [NSRC-1:0]       elig;
  logic                  win_valid;
  logic [IDX_W-1:0]      win_idx;
  logic [BID_W-1:0]      win_bid;
  logic                  above;
  cir_t                  vec;
  cir_t                  cir_q;

  irqbid_bidgen #(.BID_W(BID_W)) u_bidgen (
    .src_act (src_act),
    .src_en  (src_en),
    .rx_fill (rx_fill),
    .tx_free (tx_free),
    .rx_ofs  (rx_ofs),
    .tx_ofs  (tx_ofs),
    .oth_bid (oth_bid),
    .bid_flat(bid_flat),
    .elig    (elig)
  );

  irqbid_arb #(.BID_W(BID_W)) u_arb (
    .bid_flat (bid_flat),
    .elig     (elig),
    .win_valid(win_valid),
    .win_idx  (win_idx),
    .win_bid  (win_bid)
  );

  assign above = win_valid && (win_bid > thresh);

  irqbid_enc u_enc (
    .hit    (above),
    .win_idx(win_idx),
    .rx_fill(rx_fill),
    .tx_free(tx_free),
    .vec    (vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq   <= 1'b0;
      cir_q <= '0;
    end else begin
      irq <= above;
      if (upd_strobe) cir_q <= vec;
    end
  end

  assign cir = cir_q;

  // The arbiter's pick must be a source the bid stage marked eligible.
  assert_winner_eligible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> elig[win_idx]);

  // A transmit entry in the vector never carries a zero free count.
  assert_tx_not_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cir[7:6] == 2'b10 |-> cir[5:1] != 5'd0);

  // An empty class field only ever comes with an all-zero vector.
  assert_empty_vector_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cir[7:6] == 2'b00 |-> cir == 8'h00);

  // Event entries keep [5:4] clear and a nonzero code.
  assert_event_layout_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cir[7:6] == 2'b11 |-> (cir[5:4] == 2'b00 && cir[3:1] != 3'd0));

  // The vector holds at every edge without a strobe.
  assert_vector_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_strobe |=> $stable(cir));

  // After a strobe, a nonzero vector and the request agree.
  assert_irq_matches_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |=> ((cir != 8'h00) == irq));
endmodule

// File: tb/tb_irqbid_arbiter.sv
module tb_irqbid_arbiter;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [17:0] act = '0;
  logic [17:0] en = '0;
  logic [9:0] rx_fill, tx_free;
  logic [2*BW-1:0] rx_ofs, tx_ofs;
  logic [14*BW-1:0] oth_bid;
  logic [BW-1:0] thresh;
  logic upd = 1'b0;
  logic irq;
  logic [7:0] cir;

  int rxf[2], txf[2], rxo[2], txo[2], thr;
  int ob[2][7];

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] c;
    logic       q;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  always_comb begin
    for (int ch = 0; ch < 2; ch++) begin
      rx_fill[ch*5 +: 5] = 5'(rxf[ch]);
      tx_free[ch*5 +: 5] = 5'(txf[ch]);
      rx_ofs[ch*BW +: BW] = BW'(rxo[ch]);
      tx_ofs[ch*BW +: BW] = BW'(txo[ch]);
      for (int o = 0; o < 7; o++) oth_bid[(ch*7+o)*BW +: BW] = BW'(ob[ch][o]);
    end
    thresh = BW'(thr);
  end

  irqbid_arbiter #(.BID_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .src_act(act), .src_en(en),
    .rx_fill(rx_fill), .tx_free(tx_free), .rx_ofs(rx_ofs), .tx_ofs(tx_ofs),
    .oth_bid(oth_bid), .thresh(thresh), .upd_strobe(upd), .irq(irq), .cir(cir)
  );

  // Reference model built from the requirements.
  function automatic void model(output logic [7:0] ec, output logic eq);
    int best = -1;
    int bi = -1;
    for (int i = 0; i < 18; i++) begin
      int ch = i / 9;
      int k = i % 9;
      int b;
      if (!(act[i] && en[i])) continue;
      if (k == 1 && txf[ch] == 0) continue;
      if (k == 0) b = rxf[ch] + rxo[ch];
      else if (k == 1) b = txf[ch] + txo[ch];
      else b = ob[ch][k-2];
      if (b > 255) b = 255;
      if (b > best) begin best = b; bi = i; end
    end
    ec = 8'h00;
    eq = 1'b0;
    if (bi >= 0 && best > thr) begin
      int ch = bi / 9;
      int k = bi % 9;
      eq = 1'b1;
      if (k == 0) ec = {2'b01, 5'(rxf[ch]), 1'(ch)};
      else if (k == 1) ec = {2'b10, 5'(txf[ch]), 1'(ch)};
      else ec = {2'b11, 2'b00, 3'(k-1), 1'(ch)};
    end
  endfunction

  task automatic check(string tag, logic [7:0] ac, logic [7:0] ex, logic aq, logic eq);
    checks++;
    if (ac !== ex || aq !== eq) begin
      fails++;
      $display("FAIL %s cir=%02h irq=%b expected cir=%02h irq=%b", tag, ac, aq, ex, eq);
    end
  endtask

  function automatic int sidx(int ch, int k);
    return ch * 9 + k;
  endfunction

  task automatic clear_all();
    act = '0; en = '0; thr = 0;
    for (int ch = 0; ch < 2; ch++) begin
      rxf[ch] = 0; txf[ch] = 0; rxo[ch] = 0; txo[ch] = 0;
      for (int o = 0; o < 7; o++) ob[ch][o] = 0;
    end
  endtask

  task automatic arm(int i);
    act[i] = 1'b1;
    en[i] = 1'b1;
  endtask

  // Driver: called at a negedge with inputs set; pushes expectation, pulses strobe.
  task automatic strobe(string tag);
    exp_t e;
    model(e.c, e.q);
    e.tag = tag;
    sb.push_back(e);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  // Monitor: on each strobed edge, pop and compare just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      if (upd === 1'b1) begin
        #2;
        if (sb.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard underflow");
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.tag, cir, e.c, irq, e.q);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    logic [7:0] ec;
    logic eq;
    clear_all();
    repeat (3) @(negedge clk);
    check("R10 reset", cir, 8'h00, irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: active but masked, and enabled but idle
    act[sidx(0,0)] = 1'b1; rxf[0] = 9; rxo[0] = 40;
    en[sidx(1,4)] = 1'b1; ob[1][2] = 90;
    strobe("R1 masked/idle");

    // R6 receive A: 5+10 > 3 -> 0x4A
    clear_all(); arm(sidx(0,0)); rxf[0] = 5; rxo[0] = 10; thr = 3;
    strobe("R6 rx A");
    clear_all(); arm(sidx(1,0)); rxf[1] = 7; rxo[1] = 1;
    strobe("R6 rx B");

    // R2: full transmitter with a huge offset never bids
    clear_all(); arm(sidx(0,1)); txf[0] = 0; txo[0] = 250;
    strobe("R2 tx full");
    clear_all(); arm(sidx(1,1)); txf[1] = 3; txo[1] = 20;
    strobe("R6 tx B");

    // R7: break change (code 5) on A
    clear_all(); arm(sidx(0,6)); ob[0][4] = 50;
    strobe("R7 event A code5");
    clear_all(); arm(sidx(1,8)); ob[1][6] = 2;
    strobe("R7 event B code7");

    // R5: equal to threshold fails, one above passes
    clear_all(); arm(sidx(0,2)); ob[0][0] = 10; thr = 10;
    strobe("R5 bid equals thresh");
    ob[0][0] = 11;
    strobe("R5 bid above thresh");

    // R4 ties
    clear_all(); arm(sidx(0,0)); arm(sidx(1,0)); rxf[0] = 4; rxf[1] = 2; rxo[1] = 2;
    strobe("R4 tie chA over chB");
    clear_all(); arm(sidx(0,0)); arm(sidx(0,1)); rxf[0] = 6; txf[0] = 6;
    strobe("R4 tie rx over tx");
    clear_all(); arm(sidx(0,1)); arm(sidx(0,3)); txf[0] = 8; ob[0][1] = 8;
    strobe("R4 tie tx over event");
    clear_all(); arm(sidx(0,7)); arm(sidx(0,3)); ob[0][5] = 30; ob[0][1] = 30;
    strobe("R4 tie lower code");
    clear_all(); arm(sidx(0,8)); arm(sidx(1,0)); ob[0][6] = 12; rxf[1] = 12;
    strobe("R4 tie event A over rx B");
    clear_all(); arm(sidx(0,0)); arm(sidx(1,5)); rxf[0] = 3; ob[1][3] = 70;
    strobe("R4 larger bid wins");
    // R1: masked higher bidder loses to enabled lower one
    act[sidx(1,5)] = 1'b1; en[sidx(1,5)] = 1'b0;
    strobe("R1 masked high bidder");

    // R3 saturation: 31+250 saturates to 255 and beats 254
    clear_all(); arm(sidx(0,0)); arm(sidx(0,2)); rxf[0] = 31; rxo[0] = 250; ob[0][0] = 254;
    strobe("R3 saturation");

    // R8/R9: change bids without strobe; irq follows, vector holds
    clear_all(); arm(sidx(1,3)); ob[1][1] = 9; thr = 5;
    strobe("R9 load before idle");
    held = cir;
    ob[1][1] = 2;
    @(negedge clk);
    check("R9 irq drops without strobe", cir, held, irq, 1'b0);
    check("R8 vector held", cir, held, 1'b0, 1'b0);
    ob[1][1] = 40;
    @(negedge clk);
    check("R9 irq rises without strobe", cir, held, irq, 1'b1);

    // Random patterns
    for (int n = 0; n < 60; n++) begin
      act = 18'($urandom); en = 18'($urandom);
      for (int ch = 0; ch < 2; ch++) begin
        rxf[ch] = $urandom_range(31); txf[ch] = $urandom_range(31);
        rxo[ch] = $urandom_range(255); txo[ch] = $urandom_range(255);
        for (int o = 0; o < 7; o++) ob[ch][o] = $urandom_range(255);
      end
      thr = $urandom_range(255);
      strobe("R4 random");
    end
    model(ec, eq);
    @(negedge clk);
    check("R9 final irq", cir, cir, irq, eq);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule